// File: doc/BRIEF.md
# Line Transceiver Maintenance Control Register

This block is a single byte-wide control register for the maintenance functions of a line-interface transceiver. A host processor reaches it over a simple select/write/address/data bus. Six active-low control bits sit in it, and all of them reset to 1, which means "no effect". The block turns these bits into control outputs for the transmit and receive datapaths:

- a filter-reset control, which halts transmit data, keeps the transmitter quiet, clears the adaptive filter coefficients and holds the receiver in reset;
- a test control, which works with the filter-reset bit to enter a continuous test-tone mode;
- four reserved-bit values for the outgoing frame.

A small sequencer follows the order of the writes that arms the test-tone mode. It has four states:

- `ST_IDLE`: no test activity.
- `ST_ARMED`: the filter-reset bit and the test bit are both 0.
- `ST_TEST`: the filter-reset bit went back to 1 while the test bit stayed 0.
- `ST_EXIT`: one cycle after the test bit returns to 1.

The transitions are:

- IDLE→ARMED when both bits are 0.
- ARMED→IDLE when the test bit is 1.
- ARMED→TEST when the filter-reset bit is 1 and the test bit is 0.
- TEST→EXIT when the test bit is 1.
- TEST→ARMED when the filter-reset bit drops back to 0.
- EXIT→IDLE always.
- Any state goes to IDLE while the automatic-control input is 1.

The state `ST_EXIT` produces a one-clock internal transceiver reset pulse.

When the automatic-control input is 1, every output behaves as if all six bits were 1. Reads still return the stored contents.

Top module: `lxcvr_maint_ctl`

## Requirements
- R1: After reset the register reads 0x3F, and tone_en, rx_rst, tx_halt, coef_clr and xcvr_rst_pulse are all 0.
- R2: While auto_ctl is 1, the outputs tone_en, rx_rst, tx_halt, coef_clr and xcvr_rst_pulse are 0, and rsv_pair, rsv_a and rsv_b are all 1, whatever the register holds.
- R3: Test mode starts after two writes in order. The first write sets bit 1 (filter reset) and bit 0 (test) both to 0. A later write sets bit 1 to 1 with bit 0 still 0. tone_en and rx_rst rise on the second clock edge after that later write and stay high while the test bit stays 0.
- R4: A write of bit 0 = 0 with bit 1 = 1 from idle, with no earlier write that had both bits 0, leaves tone_en at 0.
- R5: Once test mode is active, writing bit 0 back to 1 produces exactly one cycle of xcvr_rst_pulse, and tone_en then falls to 0.
- R6: While bit 1 is 0 (and auto_ctl is 0), tx_halt, coef_clr and rx_rst are 1. The other register bits keep their written values.
- R7: rsv_pair follows bits 3:2, rsv_a follows bit 4 and rsv_b follows bit 5 while auto_ctl is 0.
- R8: The register answers only at address 0x06. Writes to other addresses are ignored, and reads of other addresses return 0. Bits 7:6 read as 0 and ignore writes.
- R9: A read returns the stored bits whatever the value of auto_ctl.
- R10: If auto_ctl rises while test mode is active, the sequencer returns to idle and no xcvr_rst_pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_ctl | input | 1 | Automatic-control mode; 1 masks the register |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tone_en | output | 1 | Continuous test-tone enable to transmitter |
| rx_rst | output | 1 | Receiver reset hold |
| tx_halt | output | 1 | Halt transmit data and force transmitter quiet |
| coef_clr | output | 1 | Clear adaptive filter coefficients |
| xcvr_rst_pulse | output | 1 | One-cycle internal transceiver reset on test exit |
| rsv_pair | output | 2 | Reserved-bit pair for outgoing frame |
| rsv_a | output | 1 | Reserved bit A for outgoing frame |
| rsv_b | output | 1 | Reserved bit B for outgoing frame |

## Verification
A sequencer stuck in the wrong state shows at the ports within two clock edges of the write that should move it.

- A missed ARMED→TEST step leaves tone_en low after the completing write.
- A false entry raises tone_en after an out-of-order write.
- An extra or missing EXIT cycle shows as a count of xcvr_rst_pulse cycles other than one in the window after test mode ends.

A masking fault under auto_ctl shows at once, since the output decode is combinational on the stored bits and the state.

// File: rtl/lxm_pkg.sv
package lxm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_TEST  = 2'd2,
        ST_EXIT  = 2'd3
    } seq_state_e;

    localparam int CTL_W      = 6;
    localparam int BIT_TST    = 0;
    localparam int BIT_FLT    = 1;
    localparam int BIT_RSVP   = 2;
    localparam int RSVP_W     = 2;
    localparam int BIT_RSVA   = 4;
    localparam int BIT_RSVB   = 5;
endpackage

// File: rtl/lxm_regfile.sv
module lxm_regfile #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter int                CTL_W    = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CTL_W-1:0]  ctl_q
);
    localparam int PAD_W = DATA_W - CTL_W;

    logic hit;
    assign hit = sel && (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '1;
        end else if (hit && wr) begin
            ctl_q <= wdata[CTL_W-1:0];
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                rdata = '0;
                if (hit && !wr) rdata = {{PAD_W{1'b0}}, ctl_q};
            end
        end else begin : g_nopad
            always_comb begin
                rdata = '0;
                if (hit && !wr) rdata = ctl_q[DATA_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/lxm_seq_fsm.sv
module lxm_seq_fsm
    import lxm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_ctl,
    input  logic       tst_n,
    input  logic       flt_n,
    output seq_state_e state
);
    seq_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (auto_ctl) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (!flt_n && !tst_n) state_nx = ST_ARMED;
                ST_ARMED: begin
                    if (tst_n)      state_nx = ST_IDLE;
                    else if (flt_n) state_nx = ST_TEST;
                end
                ST_TEST: begin
                    if (tst_n)       state_nx = ST_EXIT;
                    else if (!flt_n) state_nx = ST_ARMED;
                end
                ST_EXIT:  state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lxm_out_map.sv
module lxm_out_map
    import lxm_pkg::*;
(
    input  seq_state_e        state,
    input  logic              auto_ctl,
    input  logic [CTL_W-1:0]  ctl_q,
    output logic              tone_en,
    output logic              rx_rst,
    output logic              tx_halt,
    output logic              coef_clr,
    output logic              xcvr_rst_pulse,
    output logic [RSVP_W-1:0] rsv_pair,
    output logic              rsv_a,
    output logic              rsv_b
);
    logic [CTL_W-1:0] eff;
    logic             flt_on;

    always_comb begin
        eff    = auto_ctl ? '1 : ctl_q;
        flt_on = !eff[BIT_FLT];
        tone_en        = 1'b0;
        rx_rst         = flt_on;
        tx_halt        = flt_on;
        coef_clr       = flt_on;
        xcvr_rst_pulse = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: ;
            ST_TEST: begin
                tone_en = !flt_on && !auto_ctl;
                rx_rst  = !auto_ctl;
            end
            ST_EXIT:  xcvr_rst_pulse = !auto_ctl;
            default:  ;
        endcase
        rsv_pair = eff[BIT_RSVP +: RSVP_W];
        rsv_a    = eff[BIT_RSVA];
        rsv_b    = eff[BIT_RSVB];
    end
endmodule

// File: rtl/lxcvr_maint_ctl.sv
module lxcvr_maint_ctl
    import lxm_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_ctl,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tone_en,
    output logic              rx_rst,
    output logic              tx_halt,
    output logic              coef_clr,
    output logic              xcvr_rst_pulse,
    output logic [1:0]        rsv_pair,
    output logic              rsv_a,
    output logic              rsv_b
);
    logic [CTL_W-1:0] ctl_q;
    seq_state_e       seq_state;

    lxm_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W), .REG_ADDR(REG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .ctl_q(ctl_q)
    );

    lxm_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .auto_ctl(auto_ctl),
        .tst_n(ctl_q[BIT_TST]), .flt_n(ctl_q[BIT_FLT]), .state(seq_state)
    );

    lxm_out_map u_map (
        .state(seq_state), .auto_ctl(auto_ctl), .ctl_q(ctl_q),
        .tone_en(tone_en), .rx_rst(rx_rst), .tx_halt(tx_halt),
        .coef_clr(coef_clr), .xcvr_rst_pulse(xcvr_rst_pulse),
        .rsv_pair(rsv_pair), .rsv_a(rsv_a), .rsv_b(rsv_b)
    );
endmodule

// File: rtl/lxcvr_maint_ctl_chk.sv
module lxcvr_maint_ctl_chk
    import lxm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_ctl,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tone_en,
    input logic              rx_rst,
    input logic              tx_halt,
    input logic              coef_clr,
    input logic              xcvr_rst_pulse,
    input logic [1:0]        rsv_pair,
    input logic              rsv_a,
    input logic              rsv_b,
    input seq_state_e        seq_state
);
    p_auto_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ctl |-> (!tone_en && !rx_rst && !tx_halt && !coef_clr &&
                      !xcvr_rst_pulse && rsv_pair == 2'b11 && rsv_a && rsv_b));

    p_tone_holds_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tone_en |-> rx_rst);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_rst_pulse |=> !xcvr_rst_pulse);

    p_pulse_after_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xcvr_rst_pulse) |-> $past(seq_state == ST_TEST));

    p_tone_not_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tone_en |-> !tx_halt);

    p_hi_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:CTL_W] == '0);

    p_auto_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ctl |=> (seq_state == ST_IDLE));
endmodule

bind lxcvr_maint_ctl lxcvr_maint_ctl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .auto_ctl(auto_ctl), .bus_rdata(bus_rdata),
    .tone_en(tone_en), .rx_rst(rx_rst), .tx_halt(tx_halt), .coef_clr(coef_clr),
    .xcvr_rst_pulse(xcvr_rst_pulse), .rsv_pair(rsv_pair), .rsv_a(rsv_a),
    .rsv_b(rsv_b), .seq_state(seq_state)
);

// File: tb/lxcvr_maint_ctl_bench.sv
module lxcvr_maint_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_ctl = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tone_en, rx_rst, tx_halt, coef_clr, xcvr_rst_pulse;
    logic [1:0] rsv_pair;
    logic       rsv_a, rsv_b;

    int checks = 0;
    int fails  = 0;
    int pulse_cnt = 0;

    always #2 clk = ~clk;

    lxcvr_maint_ctl u_lxcvr_maint_ctl (
        .clk(clk), .rst_n(rst_n), .auto_ctl(auto_ctl), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tone_en(tone_en), .rx_rst(rx_rst),
        .tx_halt(tx_halt), .coef_clr(coef_clr), .xcvr_rst_pulse(xcvr_rst_pulse),
        .rsv_pair(rsv_pair), .rsv_a(rsv_a), .rsv_b(rsv_b)
    );

    always @(negedge clk) if (xcvr_rst_pulse) pulse_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset_r1();
        logic [7:0] d;
        rd_reg(8'h06, d);
        chk("R1 read", d, 8'h3F);
        chk("R1 outs", {tone_en, rx_rst, tx_halt, coef_clr, xcvr_rst_pulse}, 0);
    endtask

    task automatic t_enter_exit_r3_r5();
        wr_reg(8'h06, 8'h3C);
        wr_reg(8'h06, 8'h3E);
        chk("R3 not yet", tone_en, 0);
        @(negedge clk);
        chk("R3 tone", tone_en, 1);
        chk("R3 rx_rst", rx_rst, 1);
        chk("R3 no halt", tx_halt, 0);
        repeat (3) @(negedge clk);
        chk("R3 held", tone_en, 1);
        pulse_cnt = 0;
        wr_reg(8'h06, 8'h3F);
        repeat (4) @(negedge clk);
        chk("R5 pulse count", pulse_cnt, 1);
        chk("R5 tone off", tone_en, 0);
    endtask

    task automatic t_out_of_order_r4();
        wr_reg(8'h06, 8'h3E);
        repeat (3) @(negedge clk);
        chk("R4 no tone", tone_en, 0);
        wr_reg(8'h06, 8'h3F);
    endtask

    task automatic t_filter_r6();
        logic [7:0] d;
        wr_reg(8'h06, 8'h2D);
        chk("R6 halt/clr/rx", {tx_halt, coef_clr, rx_rst, tone_en}, 4'b1110);
        rd_reg(8'h06, d);
        chk("R6 readback", d, 8'h2D);
        wr_reg(8'h06, 8'h3F);
        chk("R6 release", {tx_halt, coef_clr, rx_rst}, 0);
    endtask

    task automatic t_rsv_r7();
        wr_reg(8'h06, 8'h13);
        chk("R7 pattern1", {rsv_b, rsv_a, rsv_pair}, 4'b0100);
        wr_reg(8'h06, 8'h2B);
        chk("R7 pattern2", {rsv_b, rsv_a, rsv_pair}, 4'b1010);
    endtask

    task automatic t_decode_r8();
        logic [7:0] d;
        wr_reg(8'h06, 8'h3F);
        wr_reg(8'h05, 8'h00);
        rd_reg(8'h06, d);
        chk("R8 other addr write", d, 8'h3F);
        wr_reg(8'h06, 8'hFF);
        rd_reg(8'h06, d);
        chk("R8 top bits", d, 8'h3F);
        rd_reg(8'h05, d);
        chk("R8 other addr read", d, 8'h00);
    endtask

    task automatic t_auto_r2_r9();
        logic [7:0] d;
        wr_reg(8'h06, 8'h11);
        auto_ctl = 1'b1;
        #1;
        chk("R2 mask ctl", {tone_en, rx_rst, tx_halt, coef_clr, xcvr_rst_pulse}, 0);
        chk("R2 mask rsv", {rsv_b, rsv_a, rsv_pair}, 4'hF);
        rd_reg(8'h06, d);
        chk("R9 readback", d, 8'h11);
        @(negedge clk);
        auto_ctl = 1'b0;
        wr_reg(8'h06, 8'h3F);
    endtask

    task automatic t_auto_in_test_r10();
        wr_reg(8'h06, 8'h3C);
        wr_reg(8'h06, 8'h3E);
        @(negedge clk);
        chk("R10 in test", tone_en, 1);
        pulse_cnt = 0;
        auto_ctl = 1'b1;
        repeat (2) @(negedge clk);
        auto_ctl = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 tone after", tone_en, 0);
        wr_reg(8'h06, 8'h3F);
        repeat (3) @(negedge clk);
        chk("R10 no pulse", pulse_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_enter_exit_r3_r5();
        t_out_of_order_r4();
        t_filter_r6();
        t_rsv_r7();
        t_decode_r8();
        t_auto_r2_r9();
        t_auto_in_test_r10();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule